// File: doc/BRIEF.md
# Two-Radio Coexistence Slot Arbiter

This block lets a classic link controller and a low-energy link controller share one radio front end. Each side raises a request line. The arbiter hands out the radio in whole slots, counted in microsecond ticks. Whenever the owner changes, it leaves the radio idle for a programmable dead gap.

The next owner is chosen in one of two ways. In priority mode, the requester with the larger 4-bit priority wins, and a tie goes to the side that did not hold the previous slot. In round-robin mode, the two sides alternate. Hold mode keeps the low-energy side off the air while the classic side wants the radio.

Each side also reports a signal-strength magnitude. A side whose magnitude is below the programmed threshold counts as stronger than the threshold and is boosted. A boosted side beats an unboosted one in either arbitration mode. It may also cut short an unboosted owner's slot, and the dead gap still follows.

Software sets the block up through a small register bus. Request, grant and tick pins are plain levels with no handshake. A requester simply keeps its line high for as long as it wants the radio.

Top module: `radio_share_arb`

## Requirements
- R1: After reset both grants are low, the control register reads 0, the slot register reads 625 and the guard register reads 30.
- R2: While the enable bit (bit 0 of the register at 0x00) is clear, both grants are low from the following cycle on, and the next grant after re-enabling starts without a gap.
- R3: The two grants are never high in the same cycle, and no grant is high while a guard gap runs.
- R4: A grant lasts exactly the slot register's number of ticks. A new request that arrives during a slot does not end it unless a boost or hold applies.
- R5: A change of owner leaves both grants low for exactly the guard register's number of ticks. When the same owner wins the next slot, its grant stays high with no gap.
- R6: With bit 1 of 0x00 clear (priority mode), the larger priority wins. The classic priority sits in bits [3:0] of 0x04 and the low-energy priority in bits [7:4].
- R7: In priority mode with equal priorities and both requesting, ownership alternates every slot. When no previous owner exists, the classic side goes first.
- R8: With bit 1 of 0x00 set (round-robin), both requesting sides alternate slot by slot whatever their priorities.
- R9: With bit 2 of 0x00 set (hold), the low-energy grant falls within one cycle of a classic request and stays low while that request stays high.
- R10: A side whose signal magnitude is below the threshold register (0x10) is boosted. A boosted requester ends an unboosted owner's slot on the next cycle and is granted after the guard gap.
- R11: Slot and guard timing advance only on cycles where the tick input is high.
- R12: Every register reads back the value last written to it, at offsets 0x00, 0x04, 0x08, 0x0C and 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read otherwise |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cl_req | input | 1 | Classic side wants the radio |
| le_req | input | 1 | Low-energy side wants the radio |
| cl_rssi | input | 8 | Classic signal magnitude in dB (70 means -70 dBm) |
| le_rssi | input | 8 | Low-energy signal magnitude in dB |
| tick_1us | input | 1 | One-cycle pulse each microsecond |
| cl_gnt | output | 1 | Radio granted to the classic side |
| le_gnt | output | 1 | Radio granted to the low-energy side |

## Verification
The hardest case to reach from the ports is a slot ended before its time. The bench has to hold an unboosted owner inside a live slot while the other side is already requesting. It then lowers only the waiting side's magnitude below the threshold, so that a boost is the single thing that changes. The bench does the same for hold mode, raising the classic request during a low-energy slot. In both cases it checks that the grant falls on the very next cycle and that a full guard gap follows. A separate test freezes the tick to show that a slot then never ends, even with both sides requesting.

// File: rtl/coex_pkg.sv
package coex_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRIO  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SLOT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_GUARD = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_THR   = 5'h10;

  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_CL = 2'd1, OWN_LE = 2'd2} owner_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_GRANT = 2'd1, ST_GUARD = 2'd2} state_e;

  // Choose the next owner. A boost outranks plain priority in both modes.
  function automatic owner_e pick_owner(input logic rc, input logic rl,
                                        input logic bc, input logic bl,
                                        input logic rr,
                                        input logic [7:0] pc, input logic [7:0] pl,
                                        input owner_e prev);
    if (!rc && !rl) return OWN_NONE;
    if (rc && !rl) return OWN_CL;
    if (!rc && rl) return OWN_LE;
    if (bc != bl) return bc ? OWN_CL : OWN_LE;
    if (!rr && (pc != pl)) return (pc > pl) ? OWN_CL : OWN_LE;
    return (prev == OWN_CL) ? OWN_LE : OWN_CL;
  endfunction

endpackage

// File: rtl/coex_regs.sv
module coex_regs
  import coex_pkg::*;
#(
  parameter int DW        = 16,
  parameter int PW        = 4,
  parameter int RW        = 8,
  parameter int SLOT_RST  = 625,
  parameter int GUARD_RST = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic              rr,
  output logic              hold,
  output logic [PW-1:0]     prio_cl,
  output logic [PW-1:0]     prio_le,
  output logic [DW-1:0]     slot_len,
  output logic [DW-1:0]     guard_len,
  output logic [RW-1:0]     thr
);

  logic [2:0]      ctrl_q;
  logic [2*PW-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      prio_q    <= '0;
      slot_len  <= DW'(SLOT_RST);
      guard_len <= DW'(GUARD_RST);
      thr       <= '0;
    end else if (sel && wr) begin
      case (addr)
        OFS_CTRL:  ctrl_q    <= wdata[2:0];
        OFS_PRIO:  prio_q    <= wdata[2*PW-1:0];
        OFS_SLOT:  slot_len  <= wdata;
        OFS_GUARD: guard_len <= wdata;
        OFS_THR:   thr       <= wdata[RW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL:  rdata = DW'(ctrl_q);
      OFS_PRIO:  rdata = DW'(prio_q);
      OFS_SLOT:  rdata = slot_len;
      OFS_GUARD: rdata = guard_len;
      OFS_THR:   rdata = DW'(thr);
      default:   rdata = '0;
    endcase
  end

  assign en      = ctrl_q[0];
  assign rr      = ctrl_q[1];
  assign hold    = ctrl_q[2];
  assign prio_cl = prio_q[PW-1:0];
  assign prio_le = prio_q[2*PW-1:PW];

endmodule

// File: rtl/coex_slot_fsm.sv
module coex_slot_fsm
  import coex_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rr,
  input  logic          hold,
  input  logic [PW-1:0] prio_cl,
  input  logic [PW-1:0] prio_le,
  input  logic          cl_boost,
  input  logic          le_boost,
  input  logic          cl_req,
  input  logic          le_req,
  input  logic          tick,
  input  logic [DW-1:0] slot_len,
  input  logic [DW-1:0] guard_len,
  output logic          gnt_cl,
  output logic          gnt_le
);

  state_e        st;
  owner_e        own, last, win, pre;
  logic [DW-1:0] cnt;
  logic [DW:0]   cnt_nx;
  logic          le_ok;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign le_ok  = le_req && !(hold && cl_req);

  always_comb begin
    win = pick_owner(cl_req, le_ok, cl_boost, le_boost, rr,
                     8'(prio_cl), 8'(prio_le), (st == ST_GRANT) ? own : last);
    pre = OWN_NONE;
    if (st == ST_GRANT) begin
      if (own == OWN_LE && cl_req && (hold || (cl_boost && !le_boost))) pre = OWN_CL;
      else if (own == OWN_CL && le_ok && le_boost && !cl_boost) pre = OWN_LE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; own <= OWN_NONE; last <= OWN_NONE; cnt <= '0;
    end else if (!en) begin
      st <= ST_IDLE; own <= OWN_NONE; last <= OWN_NONE; cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (win != OWN_NONE) begin
          own <= win;
          cnt <= '0;
          st  <= (last != OWN_NONE && last != win && guard_len != '0) ? ST_GUARD : ST_GRANT;
        end
        ST_GRANT: begin
          if (pre != OWN_NONE) begin
            last <= own; own <= pre; cnt <= '0;
            st   <= (guard_len != '0) ? ST_GUARD : ST_GRANT;
          end else if (tick) begin
            if (cnt_nx >= {1'b0, slot_len}) begin
              cnt <= '0;
              if (win == OWN_NONE) begin
                st <= ST_IDLE; last <= own; own <= OWN_NONE;
              end else if (win != own) begin
                last <= own; own <= win;
                st   <= (guard_len != '0) ? ST_GUARD : ST_GRANT;
              end
            end else begin
              cnt <= cnt_nx[DW-1:0];
            end
          end
        end
        ST_GUARD: begin
          if (hold && cl_req && own == OWN_LE) own <= OWN_CL;
          if (tick) begin
            if (cnt_nx >= {1'b0, guard_len}) begin
              st <= ST_GRANT; cnt <= '0;
            end else begin
              cnt <= cnt_nx[DW-1:0];
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign gnt_cl = (st == ST_GRANT) && (own == OWN_CL);
  assign gnt_le = (st == ST_GRANT) && (own == OWN_LE);

  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gnt_cl && !gnt_le)); // R2
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold && cl_req && gnt_le) |=> !gnt_le); // R9
  AST_GAP_TO_LE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_le && $past(gnt_cl)) |-> ($past(guard_len) == '0)); // R5
  AST_GAP_TO_CL: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_cl && $past(gnt_le)) |-> ($past(guard_len) == '0)); // R5
  AST_CL_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_cl) |-> ($past(tick) || !$past(en) || $past(le_boost))); // R4
  AST_LE_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnt_le) |-> ($past(tick) || !$past(en) || $past(cl_boost) ||
                       ($past(hold) && $past(cl_req)))); // R9

endmodule

// File: rtl/radio_share_arb.sv
module radio_share_arb
  import coex_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 4,
  parameter int RW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cl_req,
  input  logic              le_req,
  input  logic [RW-1:0]     cl_rssi,
  input  logic [RW-1:0]     le_rssi,
  input  logic              tick_1us,
  output logic              cl_gnt,
  output logic              le_gnt
);

  logic          en, rr, hold;
  logic [PW-1:0] prio_cl, prio_le;
  logic [DW-1:0] slot_len, guard_len;
  logic [RW-1:0] thr;
  logic          cl_boost, le_boost;

  coex_regs #(.DW(DW), .PW(PW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .rr(rr), .hold(hold),
    .prio_cl(prio_cl), .prio_le(prio_le), .slot_len(slot_len),
    .guard_len(guard_len), .thr(thr)
  );

  // smaller magnitude = stronger signal than the threshold
  assign cl_boost = cl_rssi < thr;
  assign le_boost = le_rssi < thr;

  coex_slot_fsm #(.DW(DW), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .rr(rr), .hold(hold),
    .prio_cl(prio_cl), .prio_le(prio_le), .cl_boost(cl_boost), .le_boost(le_boost),
    .cl_req(cl_req), .le_req(le_req), .tick(tick_1us), .slot_len(slot_len),
    .guard_len(guard_len), .gnt_cl(cl_gnt), .gnt_le(le_gnt)
  );

endmodule

// File: tb/sim_radio_share_arb.sv
module sim_radio_share_arb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cl_req = 1'b0, le_req = 1'b0, tick = 1'b1;
  logic [7:0]  cl_rssi = 8'd90, le_rssi = 8'd90;
  logic        cl_gnt, le_gnt;

  int n_chk = 0, n_bad = 0, both_hi = 0, cyc = 0;

  radio_share_arb u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cl_req(cl_req), .le_req(le_req), .cl_rssi(cl_rssi), .le_rssi(le_rssi),
    .tick_1us(tick), .cl_gnt(cl_gnt), .le_gnt(le_gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (cl_gnt && le_gnt) both_hi++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output int v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  // waits out any current grant, then counts the low cycles up to the next one
  task automatic next_grant(output int who, output int gap);
    int t = 0;
    gap = 0;
    while ((cl_gnt || le_gnt) && t < 400) begin @(negedge clk); t++; end
    while (!cl_gnt && !le_gnt && t < 800) begin @(negedge clk); gap++; t++; end
    who = cl_gnt ? 1 : (le_gnt ? 2 : 0);
  endtask

  task automatic high_len(output int n);
    n = 0;
    while ((cl_gnt || le_gnt) && n < 400) begin n++; @(negedge clk); end
  endtask

  task automatic clean;
    cl_req = 1'b0; le_req = 1'b0; tick = 1'b1; cl_rssi = 8'd90; le_rssi = 8'd90;
    wr_reg(5'h00, 16'h0000);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    check(!cl_gnt && !le_gnt, "R1 grants low", int'(cl_gnt | le_gnt), 0);
    rd_reg(5'h00, v); check(v == 0, "R1 ctrl", v, 0);
    rd_reg(5'h08, v); check(v == 625, "R1 slot", v, 625);
    rd_reg(5'h0C, v); check(v == 30, "R1 guard", v, 30);
  endtask

  task automatic t_regs;
    int v;
    wr_reg(5'h04, 16'h00A7); rd_reg(5'h04, v); check(v == 16'hA7, "R12 prio", v, 16'hA7);
    wr_reg(5'h10, 16'h0046); rd_reg(5'h10, v); check(v == 16'h46, "R12 thr", v, 16'h46);
    wr_reg(5'h00, 16'h0006); rd_reg(5'h00, v); check(v == 6, "R12 ctrl", v, 6);
    wr_reg(5'h00, 16'h0000);
    wr_reg(5'h08, 16'd8);    rd_reg(5'h08, v); check(v == 8, "R12 slot", v, 8);
    wr_reg(5'h0C, 16'd3);    rd_reg(5'h0C, v); check(v == 3, "R12 guard", v, 3);
    wr_reg(5'h10, 16'd70);
  endtask

  task automatic t_priority;
    int who, gap, n, lost;
    wr_reg(5'h04, 16'h0012); wr_reg(5'h00, 16'h0001);
    le_req = 1'b1;
    next_grant(who, gap); check(who == 2, "R6 lone le", who, 2);
    cl_req = 1'b1;
    high_len(n); check(n == 8, "R4 slot length, mid-slot request ignored", n, 8);
    next_grant(who, gap);
    check(who == 1, "R6 higher cl wins", who, 1);
    check(gap == 3, "R5 guard gap", gap, 3);
    lost = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (!cl_gnt) lost++; end
    check(lost == 0, "R5 same owner no gap", lost, 0);
    clean();
    wr_reg(5'h04, 16'h0031); wr_reg(5'h00, 16'h0001);
    cl_req = 1'b1; le_req = 1'b1;
    next_grant(who, gap); check(who == 2, "R6 higher le wins", who, 2);
    clean();
  endtask

  task automatic t_alternate(input logic [15:0] prio, input logic [15:0] ctrl, input string tag);
    int who, gap;
    wr_reg(5'h04, prio); wr_reg(5'h00, ctrl);
    cl_req = 1'b1; le_req = 1'b1;
    next_grant(who, gap); check(who == 1, {tag, " first cl"}, who, 1);
    next_grant(who, gap); check(who == 2, {tag, " then le"}, who, 2);
    check(gap == 3, {tag, " R3 gap"}, gap, 3);
    next_grant(who, gap); check(who == 1, {tag, " back to cl"}, who, 1);
    clean();
  endtask

  task automatic t_hold;
    int who, gap, bad;
    wr_reg(5'h04, 16'h0031); wr_reg(5'h00, 16'h0005);
    le_req = 1'b1;
    next_grant(who, gap); check(who == 2, "R9 le before hold", who, 2);
    @(negedge clk); cl_req = 1'b1;
    @(negedge clk); check(!le_gnt, "R9 le drops", int'(le_gnt), 0);
    next_grant(who, gap);
    check(who == 1 && gap == 3, "R9 cl after gap", who * 10 + gap, 13);
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (le_gnt) bad++; end
    check(bad == 0, "R9 le held off", bad, 0);
    cl_req = 1'b0;
    next_grant(who, gap); check(who == 2, "R9 le after release", who, 2);
    clean();
  endtask

  task automatic t_boost;
    int who, gap;
    wr_reg(5'h04, 16'h0013); wr_reg(5'h00, 16'h0001);
    cl_req = 1'b1;
    next_grant(who, gap); check(who == 1, "R10 cl owner", who, 1);
    le_req = 1'b1;
    repeat (2) @(negedge clk);
    check(cl_gnt, "R10 weak le no preempt", int'(cl_gnt), 1);
    le_rssi = 8'd60;
    @(negedge clk); check(!cl_gnt, "R10 preempt next cycle", int'(cl_gnt), 0);
    next_grant(who, gap);
    check(who == 2 && gap == 3, "R10 le after gap", who * 10 + gap, 23);
    clean();
  endtask

  task automatic t_tick;
    int who, gap, lost;
    wr_reg(5'h04, 16'h0022); wr_reg(5'h00, 16'h0001);
    tick = 1'b0; cl_req = 1'b1; le_req = 1'b1;
    next_grant(who, gap); check(who == 1, "R11 first cl", who, 1);
    lost = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!cl_gnt) lost++; end
    check(lost == 0, "R11 no tick no slot end", lost, 0);
    tick = 1'b1;
    next_grant(who, gap); check(who == 2 && gap == 3, "R11 resumes", who * 10 + gap, 23);
    clean();
  endtask

  task automatic t_disable;
    int who, gap, v;
    wr_reg(5'h00, 16'h0001);
    cl_req = 1'b1;
    next_grant(who, gap); check(who == 1, "R2 granted", who, 1);
    wr_reg(5'h00, 16'h0000);
    @(negedge clk); check(!cl_gnt && !le_gnt, "R2 grants off", int'(cl_gnt | le_gnt), 0);
    repeat (20) @(negedge clk);
    check(!cl_gnt, "R2 stays off", int'(cl_gnt), 0);
    rd_reg(5'h00, v); check(v == 0, "R2 ctrl", v, 0);
    le_req = 1'b1; cl_req = 1'b0;
    wr_reg(5'h00, 16'h0001);
    next_grant(who, gap); check(who == 2 && gap <= 2, "R2 restart without gap", gap, 1);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_priority();
    t_alternate(16'h0022, 16'h0001, "R7");
    t_alternate(16'h0015, 16'h0003, "R8");
    t_hold();
    t_boost();
    t_tick();
    t_disable();
    check(both_hi == 0, "R3 grants exclusive", both_hi, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule